// File: doc/BRIEF.md
# Variable-Length Instruction Sequencer

The sequencer is the control front end of an arithmetic engine that works on operands of any length. It reads a program from an instruction memory, one word per address, and decodes each word into an opcode and three operand addresses. Arithmetic-class instructions go to an external execution unit through a start/over handshake. That unit may take any number of cycles, because its run time grows with operand length. Jumps and undefined opcodes are handled inside the sequencer and each takes a fixed number of cycles. Conditional jumps test zero and carry flags. The sequencer captures these flags at the moment the execution unit reports completion.

A host pulses `run_i` while the block is idle. The program then starts at address 0. Each instruction word carries a marker bit that flags it as the final one. When that instruction finishes, the sequencer returns to idle and raises `done_o`. The flag stays high until the next run.

Instruction word layout, most significant bit first: bit 53 is the final-instruction marker, bits 52:48 are the opcode, bits 47:32 are operand field 0, bits 31:16 are operand field 1, and bits 15:0 are operand field 2. Opcode codes: 0 add, 1 subtract, 2 multiply, 3 vector multiply, 4 increment, 5 decrement, 6 compare, 7 unconditional jump, 8 jump if zero, 9 jump if not zero, 10 jump if carry, 11 jump if no carry, 12 move all, 13 move selected digit, 14 mask, 15 shift right. Codes 16 to 31 are undefined.

Top module: `varlen_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `done_o`, `ex_start_o` and `imem_rd_o` are 0.
- R2: A `run_i` pulse while idle produces an instruction fetch (`imem_rd_o`=1, `imem_addr_o`=0) in the next cycle. `run_i` has no effect while a program is running. A fetch never lasts more than one cycle. The memory returns the word one cycle after the fetch.
- R3: For an opcode in the set 0-6 and 12-15, `ex_start_o` is high for exactly one cycle, two cycles after that instruction's fetch cycle. In that cycle `ex_op_o` and `ex_f0_o`/`ex_f1_o`/`ex_f2_o` equal the word's opcode (bits 52:48) and fields (bits 47:32, 31:16, 15:0).
- R4: Opcode and field outputs stay stable from the start cycle until the cycle in which `ex_over_i` completes the handshake.
- R5: After the handshake completes (`ex_over_i` high in a cycle following the start cycle), the next fetch comes in the next cycle, at the incremented address. Fetch-to-fetch distance is 3 plus the number of cycles from the start cycle to the over cycle.
- R6: Opcode 7 always loads the program counter from the low `PC_W` bits of field 0. Every jump opcode (7-11) spans `JUMP_CYCLES` (default 5) cycles from its fetch to the next fetch.
- R7: Opcode 8 is taken when the zero flag is 1, opcode 9 when it is 0, opcode 10 when the carry flag is 1 and opcode 11 when it is 0. A jump that is not taken increments the counter.
- R8: The zero and carry flags are sampled from `zero_i`/`carry_i` only in the cycle that completes a handshake. Both are cleared at each run start. Flag inputs at any other time have no effect.
- R9: Opcodes 16-31 do not raise `ex_start_o`, advance the counter by one, and span `NOP_CYCLES` (default 5) cycles from fetch to next fetch.
- R10: When the instruction whose bit 53 is 1 completes (taken jump included), `done_o` rises in the cycle the next fetch would have happened. No further fetch follows. `done_o` stays 1 until the cycle after the next `run_i`.
- R11: `ex_over_i` has no effect unless a handshake is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Start program at address 0 (idle only) |
| done_o | output | 1 | Program finished; held until next run |
| imem_rd_o | output | 1 | Instruction memory read enable |
| imem_addr_o | output | PC_W | Instruction memory address |
| imem_data_i | input | 1+5+3*FLD_W | Instruction word, valid one cycle after the read |
| ex_start_o | output | 1 | One-cycle start to the execution unit |
| ex_over_i | input | 1 | Execution unit completion |
| ex_op_o | output | 5 | Opcode to the execution unit |
| ex_f0_o | output | FLD_W | Operand field 0 |
| ex_f1_o | output | FLD_W | Operand field 1 |
| ex_f2_o | output | FLD_W | Operand field 2 |
| zero_i | input | 1 | Zero flag from the execution unit |
| carry_i | input | 1 | Carry flag from the execution unit |

## Verification
Two functions can fall in the same cycle. The first is completion of a handshake, which captures the flags and advances the counter in the same cycle. The second is a change on the flag and `ex_over_i` inputs while no handshake is pending. The bench's execution-unit model drives random flag values in every cycle except the completion cycle. It also injects stray `ex_over_i` pulses while no handshake is pending, including during fetch, decode and jump padding. A fault is then judged from the fetch address chosen by each later conditional jump and from the fetch-to-fetch spacing. The reference model uses only the completion-cycle flags.

// File: rtl/varlen_seq_pkg.sv
package varlen_seq_pkg;

   localparam int OPC_W = 5;

   typedef enum logic [OPC_W-1:0] {
      OP_ADD    = 5'd0,
      OP_SUB    = 5'd1,
      OP_MUL    = 5'd2,
      OP_MULVEC = 5'd3,
      OP_INC    = 5'd4,
      OP_DEC    = 5'd5,
      OP_CMP    = 5'd6,
      OP_JMP    = 5'd7,
      OP_JZ     = 5'd8,
      OP_JNZ    = 5'd9,
      OP_JC     = 5'd10,
      OP_JNC    = 5'd11,
      OP_MOV    = 5'd12,
      OP_MOVSEL = 5'd13,
      OP_MASK   = 5'd14,
      OP_SHR    = 5'd15
   } opcode_e;

   typedef enum logic [1:0] {
      CLS_EXEC,
      CLS_JUMP,
      CLS_NOP
   } instr_cls_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH,
      S_DECODE,
      S_ISSUE,
      S_WAIT,
      S_PAD
   } seq_state_e;

   function automatic instr_cls_e op_class(input logic [OPC_W-1:0] op);
      if (op >= 5'd16)
         return CLS_NOP;
      case (op)
         OP_JMP, OP_JZ, OP_JNZ, OP_JC, OP_JNC: return CLS_JUMP;
         default:                              return CLS_EXEC;
      endcase
   endfunction

   function automatic logic jump_taken(input logic [OPC_W-1:0] op,
                                       input logic zf,
                                       input logic cf);
      case (op)
         OP_JMP:  return 1'b1;
         OP_JZ:   return zf;
         OP_JNZ:  return ~zf;
         OP_JC:   return cf;
         OP_JNC:  return ~cf;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/seq_decode.sv
module seq_decode
   import varlen_seq_pkg::*;
#(
   parameter int FLD_W = 16,
   parameter int PC_W  = 10
) (
   input  logic [1+OPC_W+3*FLD_W-1:0] word_i,
   input  logic                       zf_i,
   input  logic                       cf_i,
   output logic                       last_o,
   output logic [OPC_W-1:0]           op_o,
   output logic [FLD_W-1:0]           f0_o,
   output logic [FLD_W-1:0]           f1_o,
   output logic [FLD_W-1:0]           f2_o,
   output instr_cls_e                 cls_o,
   output logic                       taken_o,
   output logic [PC_W-1:0]            target_o
);

   localparam int WORD_W = 1 + OPC_W + 3*FLD_W;

   assign last_o  = word_i[WORD_W-1];
   assign op_o    = word_i[WORD_W-2 -: OPC_W];
   assign f0_o    = word_i[3*FLD_W-1 -: FLD_W];
   assign f1_o    = word_i[2*FLD_W-1 -: FLD_W];
   assign f2_o    = word_i[FLD_W-1:0];
   assign cls_o   = op_class(op_o);
   assign taken_o = jump_taken(op_o, zf_i, cf_i);

   // target width: full field or truncated to the counter width
   generate
      if (PC_W == FLD_W) begin : g_tgt_full
         assign target_o = f0_o;
      end else begin : g_tgt_trunc
         assign target_o = f0_o[PC_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/seq_pc.sv
module seq_pc #(
   parameter int PC_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear_i,
   input  logic            load_i,
   input  logic            inc_i,
   input  logic [PC_W-1:0] load_val_i,
   output logic [PC_W-1:0] pc_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc_o <= '0;
      else if (clear_i)
         pc_o <= '0;
      else if (load_i)
         pc_o <= load_val_i;
      else if (inc_i)
         pc_o <= pc_o + 1'b1;
   end

endmodule

// File: rtl/seq_pad_timer.sv
module seq_pad_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expired_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= load_val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
   import varlen_seq_pkg::*;
#(
   parameter int CNT_W    = 2,
   parameter int JUMP_PAD = 2,
   parameter int NOP_PAD  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             over_i,
   input  instr_cls_e       cls_i,
   input  logic             last_dec_i,
   input  logic             taken_i,
   input  logic             pad_done_i,
   output logic             fetch_o,
   output logic             issue_o,
   output logic             capture_o,
   output logic             pc_clear_o,
   output logic             pc_load_o,
   output logic             pc_inc_o,
   output logic             pad_load_o,
   output logic [CNT_W-1:0] pad_val_o,
   output logic             flag_cap_o,
   output logic             done_o
);

   seq_state_e st_q, st_d;
   logic       last_q;

   always_comb begin
      st_d       = st_q;
      capture_o  = 1'b0;
      pc_clear_o = 1'b0;
      pc_load_o  = 1'b0;
      pc_inc_o   = 1'b0;
      pad_load_o = 1'b0;
      pad_val_o  = '0;
      flag_cap_o = 1'b0;
      case (st_q)
         S_IDLE: begin
            if (run_i) begin
               st_d       = S_FETCH;
               pc_clear_o = 1'b1;
            end
         end
         S_FETCH: st_d = S_DECODE;
         S_DECODE: begin
            capture_o = 1'b1;
            case (cls_i)
               CLS_EXEC: st_d = S_ISSUE;
               CLS_JUMP: begin
                  st_d       = S_PAD;
                  pad_load_o = 1'b1;
                  pad_val_o  = CNT_W'(JUMP_PAD);
                  pc_load_o  = taken_i;
                  pc_inc_o   = ~taken_i;
               end
               default: begin
                  st_d       = S_PAD;
                  pad_load_o = 1'b1;
                  pad_val_o  = CNT_W'(NOP_PAD);
                  pc_inc_o   = 1'b1;
               end
            endcase
         end
         S_ISSUE: st_d = S_WAIT;
         S_WAIT: begin
            if (over_i) begin
               flag_cap_o = 1'b1;
               pc_inc_o   = 1'b1;
               st_d       = last_q ? S_IDLE : S_FETCH;
            end
         end
         S_PAD: begin
            if (pad_done_i)
               st_d = last_q ? S_IDLE : S_FETCH;
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         last_q <= 1'b0;
         done_o <= 1'b0;
      end else begin
         st_q <= st_d;
         if (capture_o)
            last_q <= last_dec_i;
         if (pc_clear_o)
            done_o <= 1'b0;
         else if (st_q != S_IDLE && st_d == S_IDLE)
            done_o <= 1'b1;
      end
   end

   assign fetch_o = (st_q == S_FETCH);
   assign issue_o = (st_q == S_ISSUE);

endmodule

// File: rtl/varlen_seq.sv
module varlen_seq
   import varlen_seq_pkg::*;
#(
   parameter int FLD_W       = 16,
   parameter int PC_W        = 10,
   parameter int JUMP_CYCLES = 5,
   parameter int NOP_CYCLES  = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       run_i,
   output logic                       done_o,
   output logic                       imem_rd_o,
   output logic [PC_W-1:0]            imem_addr_o,
   input  logic [1+OPC_W+3*FLD_W-1:0] imem_data_i,
   output logic                       ex_start_o,
   input  logic                       ex_over_i,
   output logic [OPC_W-1:0]           ex_op_o,
   output logic [FLD_W-1:0]           ex_f0_o,
   output logic [FLD_W-1:0]           ex_f1_o,
   output logic [FLD_W-1:0]           ex_f2_o,
   input  logic                       zero_i,
   input  logic                       carry_i
);

   // fetch + decode take two cycles; the pad covers the rest
   localparam int FIXED_OVH = 2;
   localparam int JUMP_PAD  = JUMP_CYCLES - FIXED_OVH - 1;
   localparam int NOP_PAD   = NOP_CYCLES - FIXED_OVH - 1;
   localparam int PAD_MAX   = (JUMP_PAD > NOP_PAD) ? JUMP_PAD : NOP_PAD;
   localparam int CNT_W     = (PAD_MAX < 1) ? 1 : $clog2(PAD_MAX + 1);

   generate
      if (JUMP_CYCLES < FIXED_OVH + 1) begin : g_chk_jump
         $error("JUMP_CYCLES must be at least 3");
      end
      if (NOP_CYCLES < FIXED_OVH + 1) begin : g_chk_nop
         $error("NOP_CYCLES must be at least 3");
      end
      if (PC_W < 1 || PC_W > FLD_W) begin : g_chk_pc
         $error("PC_W must lie in 1..FLD_W");
      end
   endgenerate

   logic             dec_last, dec_taken;
   logic [OPC_W-1:0] dec_op;
   logic [FLD_W-1:0] dec_f0, dec_f1, dec_f2;
   logic [PC_W-1:0]  dec_target;
   instr_cls_e       dec_cls;

   logic             capture, pc_clear, pc_load, pc_inc;
   logic             pad_load, pad_done, flag_cap;
   logic [CNT_W-1:0] pad_val;
   logic             zf_q, cf_q;

   seq_decode #(.FLD_W(FLD_W), .PC_W(PC_W)) u_dec (
      .word_i   (imem_data_i),
      .zf_i     (zf_q),
      .cf_i     (cf_q),
      .last_o   (dec_last),
      .op_o     (dec_op),
      .f0_o     (dec_f0),
      .f1_o     (dec_f1),
      .f2_o     (dec_f2),
      .cls_o    (dec_cls),
      .taken_o  (dec_taken),
      .target_o (dec_target)
   );

   seq_pc #(.PC_W(PC_W)) u_pc (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (pc_clear),
      .load_i     (pc_load),
      .inc_i      (pc_inc),
      .load_val_i (dec_target),
      .pc_o       (imem_addr_o)
   );

   seq_pad_timer #(.CNT_W(CNT_W)) u_pad (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (pad_load),
      .load_val_i (pad_val),
      .expired_o  (pad_done)
   );

   seq_ctrl #(.CNT_W(CNT_W), .JUMP_PAD(JUMP_PAD), .NOP_PAD(NOP_PAD)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run_i),
      .over_i     (ex_over_i),
      .cls_i      (dec_cls),
      .last_dec_i (dec_last),
      .taken_i    (dec_taken),
      .pad_done_i (pad_done),
      .fetch_o    (imem_rd_o),
      .issue_o    (ex_start_o),
      .capture_o  (capture),
      .pc_clear_o (pc_clear),
      .pc_load_o  (pc_load),
      .pc_inc_o   (pc_inc),
      .pad_load_o (pad_load),
      .pad_val_o  (pad_val),
      .flag_cap_o (flag_cap),
      .done_o     (done_o)
   );

   // decoded fields held for the execution unit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ex_op_o <= '0;
         ex_f0_o <= '0;
         ex_f1_o <= '0;
         ex_f2_o <= '0;
      end else if (capture) begin
         ex_op_o <= dec_op;
         ex_f0_o <= dec_f0;
         ex_f1_o <= dec_f1;
         ex_f2_o <= dec_f2;
      end
   end

   // flags captured only on handshake completion
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zf_q <= 1'b0;
         cf_q <= 1'b0;
      end else if (pc_clear) begin
         zf_q <= 1'b0;
         cf_q <= 1'b0;
      end else if (flag_cap) begin
         zf_q <= zero_i;
         cf_q <= carry_i;
      end
   end

endmodule

// File: rtl/varlen_seq_chk.sv
module varlen_seq_chk #(
   parameter int FLD_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_i,
   input logic             done_o,
   input logic             imem_rd_o,
   input logic             ex_start_o,
   input logic             ex_over_i,
   input logic [4:0]       ex_op_o,
   input logic [FLD_W-1:0] ex_f0_o,
   input logic [FLD_W-1:0] ex_f1_o,
   input logic [FLD_W-1:0] ex_f2_o
);

   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (ex_start_o)
         pend_q <= 1'b1;
      else if (ex_over_i)
         pend_q <= 1'b0;
   end

   assert_start_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ex_start_o |=> !ex_start_o);

   assert_no_start_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> !ex_start_o);

   assert_fields_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_start_o || (pend_q && !ex_over_i)) |=>
         $stable({ex_op_o, ex_f0_o, ex_f1_o, ex_f2_o}));

   assert_single_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      imem_rd_o |=> !imem_rd_o);

   assert_no_fetch_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      imem_rd_o |-> !pend_q);

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!imem_rd_o && !ex_start_o));

   assert_run_clears_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && run_i) |=> !done_o);

endmodule

bind varlen_seq varlen_seq_chk #(.FLD_W(FLD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run_i      (run_i),
   .done_o     (done_o),
   .imem_rd_o  (imem_rd_o),
   .ex_start_o (ex_start_o),
   .ex_over_i  (ex_over_i),
   .ex_op_o    (ex_op_o),
   .ex_f0_o    (ex_f0_o),
   .ex_f1_o    (ex_f1_o),
   .ex_f2_o    (ex_f2_o)
);

// File: tb/varlen_seq_test.sv
module varlen_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int FLD_W = 16;
   localparam int PC_W  = 10;
   localparam int IW    = 1 + 5 + 3*FLD_W;
   localparam int JCYC  = 5;
   localparam int NCYC  = 5;

   logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
   logic ex_over = 1'b0, zero = 1'b0, carry = 1'b0;
   logic [IW-1:0] imem_data = '0;
   logic done, imem_rd, ex_start;
   logic [PC_W-1:0] imem_addr;
   logic [4:0] ex_op;
   logic [FLD_W-1:0] ex_f0, ex_f1, ex_f2;

   logic [IW-1:0] prog [0:(1<<PC_W)-1];

   int errors = 0, checks = 0;

   varlen_seq #(.FLD_W(FLD_W), .PC_W(PC_W), .JUMP_CYCLES(JCYC), .NOP_CYCLES(NCYC)) uut (
      .clk(clk), .rst_n(rst_n), .run_i(run), .done_o(done),
      .imem_rd_o(imem_rd), .imem_addr_o(imem_addr), .imem_data_i(imem_data),
      .ex_start_o(ex_start), .ex_over_i(ex_over), .ex_op_o(ex_op),
      .ex_f0_o(ex_f0), .ex_f1_o(ex_f1), .ex_f2_o(ex_f2),
      .zero_i(zero), .carry_i(carry)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) if (imem_rd) imem_data <= prog[imem_addr];

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic bit is_exec(input logic [4:0] op);
      return (op <= 5'd6) || (op >= 5'd12 && op <= 5'd15);
   endfunction
   function automatic bit is_jump(input logic [4:0] op);
      return op >= 5'd7 && op <= 5'd11;
   endfunction
   function automatic bit taken_ref(input logic [4:0] op, input bit zf, input bit cf);
      case (op)
         5'd7:    return 1'b1;
         5'd8:    return zf;
         5'd9:    return !zf;
         5'd10:   return cf;
         5'd11:   return !cf;
         default: return 1'b0;
      endcase
   endfunction

   // reference model state
   bit              mon_on = 0, ended = 0, last_seen = 0, spur_en = 1;
   int              cyc = 0, last_fetch = 0, fetches = 0, exp_gap = 0, ex_cnt = 0, cur_lat = 0;
   logic [PC_W-1:0] exp_pc = '0;
   bit              rf_zf = 0, rf_cf = 0, ret_z = 0, ret_c = 0;
   logic [IW-1:0]   cur = '0;
   string           gap_tag = "R5";

   always @(negedge clk) begin
      if (mon_on) begin
         cyc++;
         // execution-unit model
         if (ex_start) begin
            chk(is_exec(cur[52:48]) && ex_cnt == 0, "R3 R9", "start class",
                longint'(cur[52:48]), 0);
            chk({ex_op, ex_f0, ex_f1, ex_f2} == cur[52:0], "R3", "fields at start",
                longint'({ex_op, ex_f0, ex_f1, ex_f2}), longint'(cur[52:0]));
            ex_cnt  = cur_lat;
            ex_over = 1'b0;
            zero    = 1'($urandom);
            carry   = 1'($urandom);
         end else if (ex_cnt != 0) begin
            chk({ex_op, ex_f0, ex_f1, ex_f2} == cur[52:0], "R4", "fields held",
                longint'({ex_op, ex_f0, ex_f1, ex_f2}), longint'(cur[52:0]));
            ex_cnt--;
            if (ex_cnt == 0) begin
               ex_over = 1'b1; zero = ret_z; carry = ret_c;
            end else begin
               ex_over = 1'b0; zero = 1'($urandom); carry = 1'($urandom);
            end
         end else begin
            ex_over = spur_en && ($urandom % 4 == 0);
            zero    = 1'($urandom);
            carry   = 1'($urandom);
         end
         // fetch tracking
         if (imem_rd) begin
            chk(!ended, "R10", "fetch after final", 1, 0);
            chk(imem_addr == exp_pc, gap_tag, "fetch address",
                longint'(imem_addr), longint'(exp_pc));
            if (fetches > 0)
               chk(cyc - last_fetch == exp_gap, gap_tag, "fetch spacing",
                   longint'(cyc - last_fetch), longint'(exp_gap));
            last_fetch = cyc;
            fetches++;
            cur       = prog[imem_addr];
            last_seen = cur[IW-1];
            if (is_exec(cur[52:48])) begin
               cur_lat = (cur[52:48] == 5'd4 || cur[52:48] == 5'd5) ? 8 : 1 + int'($urandom % 6);
               ret_z   = 1'($urandom);
               ret_c   = 1'($urandom);
               rf_zf   = ret_z;
               rf_cf   = ret_c;
               exp_gap = 3 + cur_lat;
               exp_pc  = imem_addr + 1'b1;
               gap_tag = "R5";
            end else if (is_jump(cur[52:48])) begin
               exp_pc  = taken_ref(cur[52:48], rf_zf, rf_cf) ? cur[32 +: PC_W] : imem_addr + 1'b1;
               exp_gap = JCYC;
               gap_tag = (cur[52:48] == 5'd7) ? "R6 R11" : "R7 R8";
            end else begin
               exp_pc  = imem_addr + 1'b1;
               exp_gap = NCYC;
               gap_tag = "R9 R11";
            end
         end
         if (last_seen && !ended && fetches > 0) begin
            if (cyc == last_fetch + exp_gap - 1)
               chk(done == 1'b0, "R10", "done early", longint'(done), 0);
            if (cyc == last_fetch + exp_gap) begin
               chk(done == 1'b1 && !imem_rd, "R10", "done at completion",
                   longint'({done, imem_rd}), 2);
               ended = 1;
            end
         end
      end
   end

   task automatic gen_prog(input int n);
      for (int i = 0; i < n; i++) begin
         logic [4:0]       op;
         logic [FLD_W-1:0] f0;
         int               r = int'($urandom % 10);
         int               tgt;
         f0 = FLD_W'($urandom);
         if (r < 5) begin
            int idx = int'($urandom % 11);
            op = (idx < 7) ? 5'(idx) : 5'(idx + 5);
         end else if (r < 8) begin
            op  = 5'(7 + $urandom % 5);
            tgt = i + 1 + int'($urandom % 3);
            if (tgt > n - 1) tgt = n - 1;
            f0[PC_W-1:0] = PC_W'(tgt);
         end else begin
            op = 5'(16 + $urandom % 16);
         end
         prog[i] = {(i == n - 1), op, f0, FLD_W'($urandom), FLD_W'($urandom)};
      end
   endtask

   task automatic run_prog(input int poke_at);
      int waited = 0;
      ended = 0; last_seen = 0; fetches = 0; ex_cnt = 0; cyc = 0;
      exp_pc = '0; rf_zf = 0; rf_cf = 0; gap_tag = "R5";
      ex_over = 1'b0;
      mon_on = 1;
      @(negedge clk); run = 1'b1;
      @(negedge clk); run = 1'b0;
      chk(imem_rd && imem_addr == 0, "R2", "first fetch at 0",
          longint'({imem_rd, imem_addr}), longint'({1'b1, {PC_W{1'b0}}}));
      chk(done == 1'b0, "R10", "run clears done", longint'(done), 0);
      while (!ended && waited < 5000) begin
         @(negedge clk);
         waited++;
         if (waited == poke_at) run = 1'b1;
         else run = 1'b0;
      end
      run = 1'b0;
      chk(ended, "R10", "program ended", longint'(ended), 1);
      repeat (4) @(negedge clk);
      chk(done == 1'b1, "R10", "done held", longint'(done), 1);
      mon_on = 0;
      ex_over = 1'b0;
   endtask

   initial begin
      int cycles = 0;
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < (1<<PC_W); i++) prog[i] = '0;
      repeat (3) @(negedge clk);
      chk({done, ex_start, imem_rd} == 3'b000, "R1", "outputs in reset",
          longint'({done, ex_start, imem_rd}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({done, ex_start, imem_rd} == 3'b000, "R1", "outputs after reset",
          longint'({done, ex_start, imem_rd}), 0);

      // directed: final marker on a taken jump stops the program
      prog[0] = {1'b0, 5'd6, 16'h0001, 16'h0002, 16'h0003};
      prog[1] = {1'b1, 5'd7, 16'hFC05, 16'h0, 16'h0};
      prog[5] = {1'b1, 5'd0, 16'h0, 16'h0, 16'h0};
      run_prog(0);

      // directed: increment/decrement, undefined opcode and each conditional jump
      prog[0] = {1'b0, 5'd4, 16'h0010, 16'h0, 16'h0};
      prog[1] = {1'b0, 5'd31, 16'h0, 16'h0, 16'h0};
      prog[2] = {1'b0, 5'd8, 16'h0004, 16'h0, 16'h0};
      prog[3] = {1'b0, 5'd9, 16'h0004, 16'h0, 16'h0};
      prog[4] = {1'b0, 5'd10, 16'h0006, 16'h0, 16'h0};
      prog[5] = {1'b0, 5'd11, 16'h0006, 16'h0, 16'h0};
      prog[6] = {1'b1, 5'd5, 16'h0, 16'h0, 16'h0};
      run_prog(0);

      // directed: run pulse mid-program has no effect (R2)
      gen_prog(12);
      run_prog(6);

      // constrained random programs
      for (int p = 0; p < 40; p++) begin
         spur_en = (p % 2 == 0);
         gen_prog(4 + int'($urandom % 17));
         run_prog((p % 5 == 0) ? 9 : 0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule